// File: doc/BRIEF.md
# Multicycle Phase and Control Sequencer

This block is the control unit of a multicycle processor core that executes one instruction over five clock cycles. An internal phase counter steps through fetch, decode, execute, memory and write-back in that order, one phase per clock, and returns to fetch after write-back. From the current phase and the opcode and function fields of the instruction register, a combinational decoder drives every write enable and multiplexer select of the datapath, together with a 2-bit ALU operation code.

Four instructions are supported: register-register add, subtract, AND and OR (one opcode, told apart by the function field), word load and word store. Register-register instructions write their result during the memory phase and leave write-back idle. A load reads memory in the memory phase and writes the register file in write-back. Any other opcode, or an unknown function code under the register-register opcode, runs through the same five phases with no enable asserted after fetch. The datapath, register file and memory are outside this block. The fetch phase never depends on the instruction fields, since the instruction register is only loaded at the end of that phase.

Top module: `mc_ctrl_seq`

## Requirements
- R1: The phases advance one per clock in the fixed order fetch, decode, execute, memory, write-back, and then return to fetch, so the fetch pattern (ir_load high) appears exactly once every five clocks.
- R2: A low rst_n sampled at a rising clock edge puts the sequencer in the fetch phase, whatever phase it was in, and it stays there while rst_n is held low.
- R3: In the fetch phase mem_rd_en, ir_load and pc_load are 1, opa_sel is 0 (PC), opb_sel is 0 (constant 4) and alu_op is 00 (add); every other output is 0, whatever the opcode and function inputs are.
- R4: In the decode phase every output is 0.
- R5: In the execute phase of a register-register instruction (opcode 0x00) opa_sel is 1 (A register), opb_sel is 1 (B register), and alu_op follows the function field: 0x20 gives 00 (add), 0x22 gives 01 (sub), 0x24 gives 10 (AND), 0x25 gives 11 (OR). All enables are 0.
- R6: In the execute phase of a load (opcode 0x23) or store (opcode 0x2B) opa_sel is 1, opb_sel is 2 (sign-extended immediate) and alu_op is 00 (add). All enables are 0.
- R7: In the memory phase of a register-register instruction rf_wr_en and wr_sel_rd are 1 (write register taken from rd), wb_sel_mdr is 0 (write data from ALU result), and every other output is 0.
- R8: In the memory phase a load asserts only mem_rd_en and a store asserts only mem_wr_en; all other outputs are 0.
- R9: In the write-back phase a load asserts rf_wr_en with wr_sel_rd 0 (write register from rt) and wb_sel_mdr 1 (write data from the memory data register); for register-register and store instructions every output is 0.
- R10: For an opcode other than 0x00, 0x23 and 0x2B, or opcode 0x00 with a function code outside 0x20, 0x22, 0x24 and 0x25, every output is 0 in the decode, execute, memory and write-back phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the phase advances on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the fetch phase |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| wr_sel_rd | output | 1 | Register write address select: 0 rt, 1 rd |
| rf_wr_en | output | 1 | Register file write enable |
| opa_sel | output | 1 | ALU operand A select: 0 PC, 1 A register |
| opb_sel | output | 2 | ALU operand B select: 0 constant 4, 1 B register, 2 sign-extended immediate |
| wb_sel_mdr | output | 1 | Register write data select: 0 ALU result, 1 memory data register |
| ir_load | output | 1 | Instruction register write enable |
| pc_load | output | 1 | Program counter write enable |
| alu_op | output | 2 | ALU operation: 00 add, 01 sub, 10 AND, 11 OR |

## Verification
A phase counter that skips, repeats or stalls shows at once as ir_load arriving earlier or later than every fifth clock, or as a memory or register write in the wrong cycle of the instruction, so every instruction is checked output by output in each of its five cycles. A wrong instruction class shows in the execute phase on the operand B select and ALU code, and one cycle later on the enable that differs between memory and register writes. An enable leaking into an idle phase (decode, or write-back of a non-load) is visible in the same cycle it is decoded, which is why the unsupported-opcode runs check that the outputs stay all zero for the four cycles after fetch.

// File: rtl/mc_ctrl_pkg.sv
// Shared types for the multicycle control sequencer.
// Assumes: five phases, two-bit ALU code, two-bit operand B select.
package mc_ctrl_pkg;

    // Execution phase of the current instruction
    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4
    } phase_t;

    // Instruction class decoded from opcode and function fields
    typedef enum logic [1:0] {
        CL_RTYPE = 2'd0,
        CL_LOAD  = 2'd1,
        CL_STORE = 2'd2,
        CL_NONE  = 2'd3
    } iclass_t;

    // ALU operation code seen by the datapath
    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } aluop_t;

    // Operand B select
    typedef enum logic [1:0] {
        OPB_FOUR = 2'd0,
        OPB_REGB = 2'd1,
        OPB_IMM  = 2'd2
    } opb_t;

    // Full control word driven to the datapath
    typedef struct packed {
        logic   mem_rd;
        logic   mem_wr;
        logic   wr_sel_rd;
        logic   rf_wr;
        logic   opa_sel;
        opb_t   opb_sel;
        logic   wb_sel_mdr;
        logic   ir_load;
        logic   pc_load;
        aluop_t alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        mem_rd: 1'b0, mem_wr: 1'b0, wr_sel_rd: 1'b0, rf_wr: 1'b0,
        opa_sel: 1'b0, opb_sel: OPB_FOUR, wb_sel_mdr: 1'b0,
        ir_load: 1'b0, pc_load: 1'b0, alu_op: ALU_ADD
    };

endpackage

// File: rtl/mc_phase_gen.sv
// Phase generator: a five-state counter that moves fetch -> decode ->
// execute -> memory -> write-back -> fetch on every rising clock edge.
// Assumes: synchronous active-low reset; no stall input, every phase
// lasts exactly one clock.
module mc_phase_gen
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);

    phase_t phase_q;
    phase_t phase_nxt;

    // Next phase: wrap after write-back, otherwise step by one
    always_comb begin
        if (phase_q == PH_WB) begin
            phase_nxt = PH_FETCH;
        end else begin
            phase_nxt = phase_t'(phase_q + 3'd1);
        end
    end

    // Phase register with synchronous reset to fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/mc_instr_class.sv
// Instruction classifier: maps the opcode and function fields to an
// instruction class and, for register-register instructions, to the ALU
// operation. Unknown opcodes and unknown function codes give CL_NONE.
// Assumes: the fields are stable for the whole instruction after fetch.
module mc_instr_class
    import mc_ctrl_pkg::*;
#(
    parameter int                 OPC_W     = 6,
    parameter int                 FN_W      = 6,
    parameter logic [OPC_W-1:0]   OPC_RTYPE = 'h00,
    parameter logic [OPC_W-1:0]   OPC_LOAD  = 'h23,
    parameter logic [OPC_W-1:0]   OPC_STORE = 'h2B,
    parameter logic [FN_W-1:0]    FN_ADD    = 'h20,
    parameter logic [FN_W-1:0]    FN_SUB    = 'h22,
    parameter logic [FN_W-1:0]    FN_AND    = 'h24,
    parameter logic [FN_W-1:0]    FN_OR     = 'h25
)(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output iclass_t          iclass,
    output aluop_t           rtype_op
);

    logic   fn_known;
    aluop_t fn_op;

    // Function-field decode for the register-register opcode
    always_comb begin
        fn_known = 1'b1;
        fn_op    = ALU_ADD;
        if (funct == FN_ADD) begin
            fn_op = ALU_ADD;
        end else if (funct == FN_SUB) begin
            fn_op = ALU_SUB;
        end else if (funct == FN_AND) begin
            fn_op = ALU_AND;
        end else if (funct == FN_OR) begin
            fn_op = ALU_OR;
        end else begin
            fn_known = 1'b0;
        end
    end

    // Opcode decode into an instruction class
    always_comb begin
        if (opcode == OPC_RTYPE) begin
            iclass = fn_known ? CL_RTYPE : CL_NONE;
        end else if (opcode == OPC_LOAD) begin
            iclass = CL_LOAD;
        end else if (opcode == OPC_STORE) begin
            iclass = CL_STORE;
        end else begin
            iclass = CL_NONE;
        end
    end

    assign rtype_op = fn_op;

endmodule

// File: rtl/mc_ctrl_decode.sv
// Control decoder: forms the datapath control word from the current
// phase and instruction class. Every field not named for a phase and
// class keeps its idle value (all enables 0, selects 0, ALU add).
// Assumes: fetch is class-independent, since the instruction register
// is loaded only at the end of fetch.
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  phase_t  phase,
    input  iclass_t iclass,
    input  aluop_t  rtype_op,
    output ctrl_t   ctrl
);

    // Phase and class to control word
    always_comb begin
        ctrl = CTRL_IDLE;
        case (phase)
            PH_FETCH: begin
                ctrl.mem_rd  = 1'b1;
                ctrl.ir_load = 1'b1;
                ctrl.pc_load = 1'b1;
            end
            PH_EXEC: begin
                if (iclass == CL_RTYPE) begin
                    ctrl.opa_sel = 1'b1;
                    ctrl.opb_sel = OPB_REGB;
                    ctrl.alu_op  = rtype_op;
                end else if (iclass == CL_LOAD || iclass == CL_STORE) begin
                    ctrl.opa_sel = 1'b1;
                    ctrl.opb_sel = OPB_IMM;
                end
            end
            PH_MEM: begin
                if (iclass == CL_RTYPE) begin
                    ctrl.rf_wr     = 1'b1;
                    ctrl.wr_sel_rd = 1'b1;
                end else if (iclass == CL_LOAD) begin
                    ctrl.mem_rd = 1'b1;
                end else if (iclass == CL_STORE) begin
                    ctrl.mem_wr = 1'b1;
                end
            end
            PH_WB: begin
                if (iclass == CL_LOAD) begin
                    ctrl.rf_wr      = 1'b1;
                    ctrl.wb_sel_mdr = 1'b1;
                end
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
// Multicycle control sequencer top: phase generator, instruction
// classifier and control decoder. Outputs are combinational from the
// phase register and the instruction fields.
// Assumes: opcode and funct come from the instruction register and are
// stable from decode to write-back.
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int FN_W  = 6
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic             wr_sel_rd,
    output logic             rf_wr_en,
    output logic             opa_sel,
    output logic [1:0]       opb_sel,
    output logic             wb_sel_mdr,
    output logic             ir_load,
    output logic             pc_load,
    output logic [1:0]       alu_op
);

    phase_t  phase;
    iclass_t iclass;
    aluop_t  rtype_op;
    ctrl_t   ctrl;

    mc_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    mc_instr_class #(
        .OPC_W (OPC_W),
        .FN_W  (FN_W)
    ) u_class (
        .opcode   (opcode),
        .funct    (funct),
        .iclass   (iclass),
        .rtype_op (rtype_op)
    );

    mc_ctrl_decode u_dec (
        .phase    (phase),
        .iclass   (iclass),
        .rtype_op (rtype_op),
        .ctrl     (ctrl)
    );

    // Unpack the control word onto the ports
    assign mem_rd_en  = ctrl.mem_rd;
    assign mem_wr_en  = ctrl.mem_wr;
    assign wr_sel_rd  = ctrl.wr_sel_rd;
    assign rf_wr_en   = ctrl.rf_wr;
    assign opa_sel    = ctrl.opa_sel;
    assign opb_sel    = ctrl.opb_sel;
    assign wb_sel_mdr = ctrl.wb_sel_mdr;
    assign ir_load    = ctrl.ir_load;
    assign pc_load    = ctrl.pc_load;
    assign alu_op     = ctrl.alu_op;

endmodule

// File: rtl/mc_ctrl_seq_chk.sv
// Assertion checker for mc_ctrl_seq, bound to the top module below.
// Relates the phase register to the control outputs over time.
module mc_ctrl_seq_chk
    import mc_ctrl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input phase_t     phase,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       wr_sel_rd,
    input logic       rf_wr_en,
    input logic       wb_sel_mdr,
    input logic       ir_load,
    input logic       pc_load
);

    // R1: phases step by one and wrap after write-back
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WB) |=> (phase == phase_t'($past(phase) + 3'd1)));

    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WB) |=> (phase == PH_FETCH));

    // R2: a sampled low reset leaves the sequencer in fetch
    a_r2_reset_fetch: assert property (@(posedge clk)
        !rst_n |=> (phase == PH_FETCH));

    // R3: the instruction register is loaded together with PC and a read
    a_r3_fetch_group: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> (pc_load && mem_rd_en && !mem_wr_en && !rf_wr_en));

    // R1: one instruction load is never followed by another at once
    a_r1_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> !ir_load);

    // R4: decode is quiet
    a_r4_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |-> !(mem_rd_en || mem_wr_en || rf_wr_en || ir_load || pc_load));

    // R8: memory read and write never overlap
    a_r8_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R7, R9: register writes only in memory (rd) or write-back (memory data)
    a_r9_rf_wr_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> ((phase == PH_MEM && wr_sel_rd && !wb_sel_mdr) ||
                      (phase == PH_WB && !wr_sel_rd && wb_sel_mdr)));

endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .wr_sel_rd  (wr_sel_rd),
    .rf_wr_en   (rf_wr_en),
    .wb_sel_mdr (wb_sel_mdr),
    .ir_load    (ir_load),
    .pc_load    (pc_load)
);

// File: tb/mc_ctrl_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for mc_ctrl_seq: one task per scenario, each checking
// the full control vector in every phase against values derived from
// the requirements.
module mc_ctrl_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic [5:0] funct = 6'h00;
    logic       mem_rd_en, mem_wr_en, wr_sel_rd, rf_wr_en, opa_sel;
    logic [1:0] opb_sel;
    logic       wb_sel_mdr, ir_load, pc_load;
    logic [1:0] alu_op;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mc_ctrl_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .funct      (funct),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .wr_sel_rd  (wr_sel_rd),
        .rf_wr_en   (rf_wr_en),
        .opa_sel    (opa_sel),
        .opb_sel    (opb_sel),
        .wb_sel_mdr (wb_sel_mdr),
        .ir_load    (ir_load),
        .pc_load    (pc_load),
        .alu_op     (alu_op)
    );

    // Actual vector: {rd, wr, sel_rd, rf_wr, opa, opb[1:0], mdr, ir, pc, alu[1:0]}
    function automatic logic [11:0] act_vec();
        return {mem_rd_en, mem_wr_en, wr_sel_rd, rf_wr_en, opa_sel, opb_sel,
                wb_sel_mdr, ir_load, pc_load, alu_op};
    endfunction

    // Expected vector per phase index (0 fetch .. 4 write-back) from R3..R10
    function automatic logic [11:0] exp_vec(int p, logic [5:0] op, logic [5:0] fn);
        logic mr = 0, mw = 0, rd = 0, rw = 0, a = 0, wm = 0, ir = 0, pc = 0;
        logic [1:0] b = 2'd0, alu = 2'd0;
        logic rt, ld, st;
        rt = (op == 6'h00) && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25);
        ld = (op == 6'h23);
        st = (op == 6'h2B);
        case (p)
            0: begin mr = 1; ir = 1; pc = 1; end
            2: begin
                if (rt) begin
                    a = 1; b = 2'd1;
                    alu = (fn == 6'h20) ? 2'd0 : (fn == 6'h22) ? 2'd1 :
                          (fn == 6'h24) ? 2'd2 : 2'd3;
                end else if (ld || st) begin
                    a = 1; b = 2'd2;
                end
            end
            3: begin
                if (rt) begin rw = 1; rd = 1; end
                else if (ld) mr = 1;
                else if (st) mw = 1;
            end
            4: if (ld) begin rw = 1; wm = 1; end
            default: ;
        endcase
        return {mr, mw, rd, rw, a, b, wm, ir, pc, alu};
    endfunction

    function automatic string tag_for(int p, logic [5:0] op, logic [5:0] fn);
        logic rt = (op == 6'h00) && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25);
        logic ls = (op == 6'h23) || (op == 6'h2B);
        if (p == 0) return "R3";
        if (!rt && !ls) return "R10";
        if (p == 1) return "R4";
        if (p == 2) return rt ? "R5" : "R6";
        if (p == 3) return rt ? "R7" : "R8";
        return "R9";
    endfunction

    task automatic check_vec(string tag, logic [11:0] exp_v);
        logic [11:0] got = act_vec();
        n_checks++;
        if (got !== exp_v) begin
            n_errors++;
            $display("FAIL %s: got %012b expected %012b at %0t", tag, got, exp_v, $time);
        end
    endtask

    // Runs one instruction through all five phases; starts at a falling edge in fetch
    task automatic run_instr(logic [5:0] op, logic [5:0] fn);
        opcode = op;
        funct  = fn;
        for (int p = 0; p < 5; p++) begin
            #1;
            check_vec(tag_for(p, op, fn), exp_vec(p, op, fn));
            @(negedge clk);
        end
    endtask

    // R2: held reset keeps the fetch pattern on every edge
    task automatic t_reset_hold();
        opcode = 6'h2B;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check_vec("R2", exp_vec(0, opcode, funct));
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R5 and R7: all four register-register functions
    task automatic t_rtype();
        run_instr(6'h00, 6'h20);
        run_instr(6'h00, 6'h22);
        run_instr(6'h00, 6'h24);
        run_instr(6'h00, 6'h25);
    endtask

    // R6, R8, R9: load and store
    task automatic t_load_store();
        run_instr(6'h23, 6'h00);
        run_instr(6'h2B, 6'h3F);
        run_instr(6'h23, 6'h25);
    endtask

    // R10: unsupported opcodes and unknown function codes
    task automatic t_unsupported();
        run_instr(6'h08, 6'h20);
        run_instr(6'h00, 6'h2A);
        run_instr(6'h3F, 6'h3F);
    endtask

    // R1: ir_load pulses exactly every fifth clock
    task automatic t_period();
        int bad = 0;
        opcode = 6'h00;
        funct  = 6'h20;
        for (int i = 0; i < 15; i++) begin
            #1;
            if (ir_load !== ((i % 5) == 0)) bad++;
            @(negedge clk);
        end
        n_checks++;
        if (bad != 0) begin
            n_errors++;
            $display("FAIL R1: got %0d misplaced fetch cycles expected 0", bad);
        end
    endtask

    // R2: reset mid-instruction returns to fetch, then a load runs normally
    task automatic t_mid_reset();
        opcode = 6'h23;
        funct  = 6'h00;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check_vec("R2", exp_vec(0, opcode, funct));
        rst_n = 1'b1;
        run_instr(6'h23, 6'h00);
    endtask

    initial begin
        t_reset_hold();
        t_rtype();
        t_load_store();
        t_unsupported();
        t_period();
        t_mid_reset();
        run_instr(6'h2B, 6'h00);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule